// File: doc/BRIEF.md
# Control Register Bank with Staged Freeze

This block is a byte-wide control register bank. A host writes and reads it over a plain address/data bus. Seven registers hold settings that must change together, such as channel volumes and a mute mask. For these registers the bank keeps a shadow copy and a live copy. A freeze bit in the control register decides when the live copies follow the host. While freeze is set, host writes land only in the shadow copies. When freeze is cleared, every pending value moves to the live outputs on the same clock edge.

The control register itself always takes effect at once. It also holds the pad settings that the bank decodes into level and output-enable signals:
- the polarity and drive type of the interrupt pin;
- a tri-state for the serial data output;
- a tri-state for a serial port's bit and frame clocks, which applies only when that port is master.

Top module: `frz_regbank`

## Requirements
- R1: While freeze is 0, a write to a freeze-able register appears on its live output slot on the clock edge that accepts the write.
- R2: While freeze is 1, writes to freeze-able registers leave every live output slot unchanged.
- R3: The write that clears freeze copies every shadow value to its live slot on that same edge, so all held settings change together.
- R4: The freeze-able registers sit at addresses 01h and 0Fh to 14h.
  - Address 01h maps to `frz_live[7:0]`.
  - Address 0Eh+k (k = 1 to 6) maps to `frz_live[8k+7:8k]`.
  - All eight bits of each register are stored.
- R5: Reads return the shadow value of a freeze-able register, including while freeze holds the live value. Unmapped addresses read 00h and ignore writes.
- R6: The control register is at address 02h and takes effect immediately. Its bit fields are:
  - bit0: interrupt polarity;
  - bit1: freeze;
  - bit2: serial data tri-state;
  - bit3: serial port clock tri-state;
  - bits 7:4: read as 0.
- R7: Interrupt pin behaviour depends on the polarity bit.
  - Polarity 1 (active-high, push-pull): `irq_oe`=1 and `irq_lvl` follows `irq_req`.
  - Polarity 0 (active-low, open-drain): `irq_lvl`=0, and `irq_oe` equals `irq_req`.
- R8: `sdout_oe` is 0 when the serial data tri-state bit is 1, and 1 otherwise.
- R9: `sp_clk_oe` is 1 only when `sp_master` is 1 and the port tri-state bit is 0. In slave mode it stays 0 whatever the bit's value.
- R10: After reset every register is 00h. This means freeze clear, interrupt in open-drain active-low mode and no tri-state asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| frz_live | output | 56 | Live values of the seven freeze-able registers |
| irq_req | input | 1 | Interrupt request from the device |
| irq_lvl | output | 1 | Interrupt pad drive level |
| irq_oe | output | 1 | Interrupt pad output enable |
| sdout_oe | output | 1 | Serial data out output enable |
| sp_master | input | 1 | Serial port is clock master |
| sp_clk_oe | output | 1 | Bit/frame clock output enable |

## Verification
The bench builds the bank with its default control address of 02h. It sweeps the whole 8-bit address space, which places every unmapped address and both edges of the 0Fh–14h window under test. A staged update is held across several writes and released in one edge. Both interrupt polarities are driven with the request high and low. The serial port clock enable is checked in every combination of master mode and the tri-state bit.

// File: rtl/frz_regbank.sv
module frz_regbank #(
  parameter logic [7:0] CTRL_ADDR = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [55:0] frz_live,
  input  logic        irq_req,
  output logic        irq_lvl,
  output logic        irq_oe,
  output logic        sdout_oe,
  input  logic        sp_master,
  output logic        sp_clk_oe
);
  localparam int NSLOT = 7;

  function automatic logic [7:0] slot_addr(int s);
    return (s == 0) ? 8'h01 : 8'(8'h0E + s);
  endfunction

  logic [3:0]  ctrl;
  logic [7:0]  shadow [NSLOT];
  logic [7:0]  live   [NSLOT];
  logic [55:0] shadow_flat;

  wire pol    = ctrl[0];
  wire frz    = ctrl[1];
  wire tri_sd = ctrl[2];
  wire tri_sp = ctrl[3];

  wire ctrl_wr     = wr_en && addr == CTRL_ADDR;
  wire release_frz = frz && ctrl_wr && !wdata[1];

  always_ff @(posedge clk)
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= wdata[3:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    wire hit = wr_en && addr == slot_addr(g);
    always_ff @(posedge clk)
      if (!rst_n) begin
        shadow[g] <= '0;
        live[g]   <= '0;
      end else begin
        if (hit) shadow[g] <= wdata;
        if (hit && !frz)   live[g] <= wdata;
        else if (release_frz) live[g] <= shadow[g];
      end
    assign frz_live[g*8 +: 8]    = live[g];
    assign shadow_flat[g*8 +: 8] = shadow[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = {4'b0, ctrl};
    for (int s = 0; s < NSLOT; s++)
      if (addr == slot_addr(s)) rdata = shadow[s];
  end

  assign irq_oe    = pol ? 1'b1 : irq_req;
  assign irq_lvl   = pol & irq_req;
  assign sdout_oe  = ~tri_sd;
  assign sp_clk_oe = sp_master & ~tri_sp;
endmodule

module frz_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic        frz,
  input logic        pol,
  input logic        ctrl_wr,
  input logic [55:0] frz_live,
  input logic [55:0] shadow_flat,
  input logic        irq_req,
  input logic        irq_lvl,
  input logic        irq_oe,
  input logic        sp_master,
  input logic        sp_clk_oe
);
  assert_immediate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !frz && addr == 8'h01) |=> frz_live[7:0] == $past(wdata));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !(ctrl_wr && !wdata[1])) |=> $stable(frz_live));

  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && ctrl_wr && !wdata[1]) |=> frz_live == shadow_flat);

  assert_od_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pol |-> (!irq_lvl && irq_oe == irq_req));

  assert_push_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pol |-> (irq_oe && irq_lvl == irq_req));

  assert_slave_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_master |-> !sp_clk_oe);
endmodule

bind frz_regbank frz_regbank_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .frz(frz), .pol(pol), .ctrl_wr(ctrl_wr), .frz_live(frz_live),
  .shadow_flat(shadow_flat), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .irq_oe(irq_oe), .sp_master(sp_master), .sp_clk_oe(sp_clk_oe)
);

// File: tb/frz_regbank_test.sv
`timescale 1ns/1ps
module frz_regbank_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, irq_req = 0, sp_master = 0;
  logic [7:0]  addr = 0, wdata = 0;
  logic [7:0]  rdata;
  logic [55:0] frz_live;
  logic        irq_lvl, irq_oe, sdout_oe, sp_clk_oe;
  int checks = 0, errors = 0;

  frz_regbank uut (.*);

  always #2.5 clk = ~clk;

  // {addr, wdata, expected read-back}
  localparam logic [23:0] VEC [11] = '{
    {8'h01, 8'h11, 8'h11}, {8'h0F, 8'h22, 8'h22}, {8'h10, 8'h33, 8'h33},
    {8'h11, 8'h44, 8'h44}, {8'h12, 8'h55, 8'h55}, {8'h13, 8'h66, 8'h66},
    {8'h14, 8'h77, 8'h77}, {8'h00, 8'h99, 8'h00}, {8'h15, 8'hAB, 8'h00},
    {8'h0E, 8'hCD, 8'h00}, {8'h02, 8'hF0, 8'h00}
  };

  function automatic int slot_of(logic [7:0] a);
    if (a == 8'h01) return 0;
    if (a >= 8'h0F && a <= 8'h14) return int'(a) - 14;
    return -1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [55:0] exp_live;
    sp_master = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 live", frz_live, 56'h0);
    rd(8'h02, r); check("R10 ctrl", r, 8'h00);
    check("R10 sdout_oe", sdout_oe, 1);
    check("R10 sp_clk_oe", sp_clk_oe, 1);
    check("R10 irq_oe", irq_oe, 0);

    // R1 R4 R5 R6 vector walk, freeze clear
    exp_live = '0;
    for (int i = 0; i < 11; i++) begin
      logic [7:0] a, d, e;
      int s;
      {a, d, e} = VEC[i];
      wr(a, d);
      s = slot_of(a);
      if (s >= 0) exp_live[s*8 +: 8] = d;
      check("R1/R4 live", frz_live, exp_live);
      rd(a, r); check("R5/R6 readback", r, e);
    end

    // R5 full address sweep
    for (int a = 0; a < 256; a++) begin
      int s;
      s = slot_of(8'(a));
      rd(8'(a), r);
      if (s >= 0) check("R5 sweep mapped", r, exp_live[s*8 +: 8]);
      else        check("R5 sweep unmapped", r, 8'h00);
    end

    // R2 R3 staged update
    wr(8'h02, 8'h02);
    wr(8'h01, 8'hAA);
    wr(8'h14, 8'hBB);
    wr(8'h12, 8'hCC);
    wr(8'h02, 8'h02);          // control rewrite keeping freeze
    check("R2 held", frz_live, exp_live);
    rd(8'h14, r); check("R5 shadow read while frozen", r, 8'hBB);
    rd(8'h02, r); check("R6 freeze bit", r, 8'h02);
    wr(8'h02, 8'h00);
    exp_live[7:0] = 8'hAA; exp_live[55:48] = 8'hBB; exp_live[39:32] = 8'hCC;
    check("R3 commit together", frz_live, exp_live);
    wr(8'h10, 8'h5A);
    exp_live[23:16] = 8'h5A;
    check("R1 immediate after release", frz_live, exp_live);

    // R7 interrupt modes
    irq_req = 1; #1;
    check("R7 od oe", irq_oe, 1); check("R7 od lvl", irq_lvl, 0);
    irq_req = 0; #1;
    check("R7 od released", irq_oe, 0);
    wr(8'h02, 8'h01);
    check("R7 pp low oe", irq_oe, 1); check("R7 pp low lvl", irq_lvl, 0);
    irq_req = 1; #1;
    check("R7 pp high lvl", irq_lvl, 1); check("R7 pp high oe", irq_oe, 1);

    // R8 serial data tri-state
    wr(8'h02, 8'h04);
    check("R8 tri", sdout_oe, 0);
    wr(8'h02, 8'h00);
    check("R8 drive", sdout_oe, 1);

    // R9 port clock tri-state
    sp_master = 1; wr(8'h02, 8'h08);
    check("R9 master tri", sp_clk_oe, 0);
    sp_master = 0; #1;
    check("R9 slave tri", sp_clk_oe, 0);
    wr(8'h02, 8'h00);
    check("R9 slave no tri", sp_clk_oe, 0);
    sp_master = 1; #1;
    check("R9 master drive", sp_clk_oe, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule